// File: doc/BRIEF.md
# Receive Frame and Multiframe Marker Generator

This block produces the two receive-side timing pulses that a framer presents on its system interface. It runs on the receive bit clock. An upstream synchronizer supplies three strobes: a frame-start strobe on bit 0 of each frame, a multiframe (or superframe) start strobe that coincides with a frame start, and a CAS multiframe strobe. The block keeps its own bit position within the frame. That position keeps running between strobes, so the block coasts through frames whose strobe is missing.

The frame output works in one of two modes. In marker mode it is a one-bit-period high pulse at a programmable bit offset. In sync mode it is a one-bit-period low pulse at that same offset. The multiframe output is a one-bit-period high pulse with several sources:
- in E1 operation, the CRC multiframe strobe or the CAS multiframe strobe;
- in T1/J1 operation, the superframe strobe;
- in T1/J1 operation with the 24-frame or 72-frame format selected, an extra pulse every 12 frames.

All configuration is taken from plain input ports and is sampled once per frame. Either clock edge can launch the outputs.

Top module: `rx_marker_gen`

## Requirements
- R1: After reset and until the first cycle with `fs_i` high, `mf_begin_o` is 0. Over the same span `frame_mark_o` sits at its inactive level: 0 when `sync_mode_i`=0 and 1 when `sync_mode_i`=1.
- R2: A cycle with `fs_i` high is bit position 0. Each following cycle advances the position by one. The position wraps to 0 after 255 when `t1_mode_i`=0 (256-bit frame) and after 192 when `t1_mode_i`=1 (193-bit frame). Counting continues when no strobe arrives. A strobe at any other position restarts the count at 0.
- R3: With `sync_mode_i`=0, `frame_mark_o` is 1 for exactly the one clock that follows the cycle whose position equals `offset_i` modulo the frame length. It is 0 at all other times.
- R4: With `sync_mode_i`=1, `frame_mark_o` is 0 for exactly that one clock and 1 at all other times.
- R5: With `fall_edge_i`=0, both outputs change on the rising clock edge. With `fall_edge_i`=1, both outputs change on the falling edge half a clock later.
- R6: With `t1_mode_i`=0 and `cas_en_i`=0, `mf_begin_o` is 1 for the one clock that follows each cycle with `mfs_i` high. `cas_i` has no effect.
- R7: With `t1_mode_i`=0 and `cas_en_i`=1, `mf_begin_o` follows `cas_i` in the same way. `mfs_i` has no effect.
- R8: With `t1_mode_i`=1 and `mf_sel_i`=0, `mf_begin_o` follows `mfs_i` only. Neither `cas_en_i` nor `cas_i` has any effect, and no extra pulses appear.
- R9: With `t1_mode_i`=1 and `mf_sel_i`=1, `mf_begin_o` follows `mfs_i`. It also pulses at each frame start that lies 12·k frames (k≥1) after the last `mfs_i` frame:
  - with `fmt_i`=2 (24-frame format), only while 12·k < 24;
  - with `fmt_i`=3 (72-frame format), only while 12·k < 72;
  - with `fmt_i`=0 or 1, never.
- R10: Configuration inputs are sampled only at a bit-position-0 cycle, or in any cycle before the first `fs_i`. A sampled value governs that whole frame, so a mid-frame change takes effect at the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fs_i | input | 1 | Frame-start strobe, bit 0 of a frame |
| mfs_i | input | 1 | Multiframe/superframe start strobe, coincident with a frame start |
| cas_i | input | 1 | CAS multiframe start strobe |
| t1_mode_i | input | 1 | 0: E1 line (256-bit frame), 1: T1/J1 line (193-bit frame) |
| sync_mode_i | input | 1 | 0: high marker pulse, 1: low sync pulse |
| mf_sel_i | input | 1 | T1/J1 only: 0 multiframe marking, 1 superframe marking with 12-frame extras |
| cas_en_i | input | 1 | E1 only: mark the CAS multiframe instead of the CRC multiframe |
| fmt_i | input | 2 | T1/J1 framing format: 0 12-frame, 1 4-frame, 2 24-frame, 3 72-frame |
| offset_i | input | 9 | Bit offset of the frame pulse from the frame start |
| fall_edge_i | input | 1 | 0: launch outputs on the rising edge, 1: on the falling edge |
| frame_mark_o | output | 1 | Frame marker or frame-sync pulse |
| mf_begin_o | output | 1 | Multiframe-begin pulse |

## Verification
A wrong bit position shows up on `frame_mark_o` within one frame: the pulse lands at the wrong clock, or appears twice in a frame, or goes missing. This is most visible when the strobes stop and the block coasts. A wrong frame count or a stale configuration copy affects `mf_begin_o` more slowly: an extra pulse appears in the wrong frame or is lost, which can take up to 72 frames to surface. The bench therefore runs complete 72-frame structures, and it changes configuration mid-frame so that a premature sample shows up in the following frame.

// File: rtl/rxm_pkg.sv
package rxm_pkg;

  localparam int OFF_W  = 9;
  localparam int POS_W  = 9;
  localparam int FCNT_W = 7;

  typedef enum logic [1:0] {
    FMT_F12 = 2'd0,
    FMT_F4  = 2'd1,
    FMT_F24 = 2'd2,
    FMT_F72 = 2'd3
  } t1_fmt_e;

  typedef struct packed {
    logic             t1;
    logic             sync_mode;
    logic             mf_sel;
    logic             cas_en;
    t1_fmt_e          fmt;
    logic [OFF_W-1:0] offset;
    logic             fall;
  } rxm_cfg_t;

  // Frame length in bit periods for the selected line.
  function automatic int frame_len(input logic t1, input int e1_len, input int t1_len);
    return t1 ? t1_len : e1_len;
  endfunction

  // Offset reduced into the frame.
  function automatic logic [POS_W-1:0] wrap_offset(input logic [OFF_W-1:0] off,
                                                   input logic t1,
                                                   input int e1_len, input int t1_len);
    int r;
    r = int'(off) % frame_len(t1, e1_len, t1_len);
    return r[POS_W-1:0];
  endfunction

  // Extra superframe-grouping pulse decision.
  function automatic logic is_extra(input logic [FCNT_W-1:0] fcnt, input t1_fmt_e fmt,
                                    input int group, input int len24, input int len72);
    int c;
    int lim;
    c   = int'(fcnt);
    lim = (fmt == FMT_F72) ? len72 : len24;
    if (fmt != FMT_F24 && fmt != FMT_F72) return 1'b0;
    return (c != 0) && (c % group == 0) && (c < lim);
  endfunction

endpackage

// File: rtl/rxm_bit_pos.sv
module rxm_bit_pos
  import rxm_pkg::*;
#(
  parameter int E1_LEN = 256,
  parameter int T1_LEN = 193
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_i,
  input  rxm_cfg_t         cfg_in,
  output logic [POS_W-1:0] pos_o,
  output logic             lock_o,
  output logic             bound_o,
  output logic             load_o,
  output rxm_cfg_t         cfg_o
);

  logic [POS_W-1:0] pos_q;
  logic             lock_q;
  rxm_cfg_t         cfg_q;
  logic [POS_W-1:0] last_pos;

  assign last_pos = POS_W'(frame_len(cfg_q.t1, E1_LEN, T1_LEN) - 1);

  always_comb begin
    if (fs_i)                  pos_o = '0;
    else if (pos_q == last_pos) pos_o = '0;
    else                       pos_o = pos_q + 1'b1;
  end

  assign lock_o  = lock_q | fs_i;
  assign load_o  = !lock_q || (pos_o == '0);
  assign bound_o = lock_o && (pos_o == '0);
  assign cfg_o   = load_o ? cfg_in : cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      lock_q <= 1'b0;
      cfg_q  <= cfg_in;
    end else begin
      pos_q  <= pos_o;
      lock_q <= lock_o;
      cfg_q  <= cfg_o;
    end
  end

endmodule

// File: rtl/rxm_frame_cnt.sv
module rxm_frame_cnt
  import rxm_pkg::*;
#(
  parameter int GROUP  = 12,
  parameter int LEN24  = 24,
  parameter int LEN72  = 72
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_i,
  input  logic              bound_i,
  input  logic              mfs_i,
  input  t1_fmt_e           fmt_i,
  output logic [FCNT_W-1:0] fcnt_o,
  output logic              extra_o
);

  localparam logic [FCNT_W-1:0] CNT_MAX = '1;

  logic [FCNT_W-1:0] fcnt_q;

  always_comb begin
    if (mfs_i && lock_i)                 fcnt_o = '0;
    else if (bound_i && fcnt_q != CNT_MAX) fcnt_o = fcnt_q + 1'b1;
    else                                 fcnt_o = fcnt_q;
  end

  assign extra_o = bound_i && is_extra(fcnt_o, fmt_i, GROUP, LEN24, LEN72);

  always_ff @(posedge clk) begin
    if (!rst_n) fcnt_q <= '0;
    else        fcnt_q <= fcnt_o;
  end

endmodule

// File: rtl/rxm_launch.sv
module rxm_launch #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] rst_val_i,
  input  logic         fall_sel_i,
  input  logic         fall_rst_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] q_o
);

  logic sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= fall_rst_i;
    else        sel_q <= fall_sel_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic r_b;
    logic f_b;
    always_ff @(posedge clk) begin
      if (!rst_n) r_b <= rst_val_i[i];
      else        r_b <= d_i[i];
    end
    always_ff @(negedge clk) f_b <= r_b;
    assign rise_o[i] = r_b;
    assign q_o[i]    = sel_q ? f_b : r_b;
  end

endmodule

// File: rtl/rx_marker_gen.sv
module rx_marker_gen
  import rxm_pkg::*;
#(
  parameter int E1_LEN = 256,
  parameter int T1_LEN = 193,
  parameter int GROUP  = 12,
  parameter int LEN24  = 24,
  parameter int LEN72  = 72
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fs_i,
  input  logic       mfs_i,
  input  logic       cas_i,
  input  logic       t1_mode_i,
  input  logic       sync_mode_i,
  input  logic       mf_sel_i,
  input  logic       cas_en_i,
  input  logic [1:0] fmt_i,
  input  logic [8:0] offset_i,
  input  logic       fall_edge_i,
  output logic       frame_mark_o,
  output logic       mf_begin_o
);

  rxm_cfg_t         cfg_live;
  rxm_cfg_t         cfg_w;
  logic [POS_W-1:0] pos_w;
  logic [POS_W-1:0] off_w;
  logic             lock_w;
  logic             bound_w;
  logic             load_w;
  logic [FCNT_W-1:0] fcnt_w;
  logic             extra_w;
  logic             hit_w;
  logic             fm_lvl_w;
  logic             mf_src_w;
  logic             mf_act_w;
  logic [1:0]       rise_w;
  logic [1:0]       out_w;

  assign cfg_live = '{t1: t1_mode_i, sync_mode: sync_mode_i, mf_sel: mf_sel_i,
                      cas_en: cas_en_i, fmt: t1_fmt_e'(fmt_i), offset: offset_i,
                      fall: fall_edge_i};

  rxm_bit_pos #(.E1_LEN(E1_LEN), .T1_LEN(T1_LEN)) u_pos (
    .clk(clk), .rst_n(rst_n), .fs_i(fs_i), .cfg_in(cfg_live),
    .pos_o(pos_w), .lock_o(lock_w), .bound_o(bound_w), .load_o(load_w), .cfg_o(cfg_w)
  );

  rxm_frame_cnt #(.GROUP(GROUP), .LEN24(LEN24), .LEN72(LEN72)) u_fcnt (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_w), .bound_i(bound_w), .mfs_i(mfs_i),
    .fmt_i(cfg_w.fmt), .fcnt_o(fcnt_w), .extra_o(extra_w)
  );

  assign off_w    = wrap_offset(cfg_w.offset, cfg_w.t1, E1_LEN, T1_LEN);
  assign hit_w    = lock_w && (pos_w == off_w);
  assign fm_lvl_w = cfg_w.sync_mode ? ~hit_w : hit_w;
  assign mf_src_w = (!cfg_w.t1 && cfg_w.cas_en) ? cas_i : mfs_i;
  assign mf_act_w = lock_w && (mf_src_w || (cfg_w.t1 && cfg_w.mf_sel && extra_w));

  rxm_launch #(.W(2)) u_launch (
    .clk(clk), .rst_n(rst_n),
    .d_i({mf_act_w, fm_lvl_w}),
    .rst_val_i({1'b0, sync_mode_i}),
    .fall_sel_i(cfg_w.fall), .fall_rst_i(fall_edge_i),
    .rise_o(rise_w), .q_o(out_w)
  );

  assign frame_mark_o = out_w[0];
  assign mf_begin_o   = out_w[1];

endmodule

// File: rtl/rxm_chk.sv
module rxm_chk
  import rxm_pkg::*;
#(
  parameter int E1_LEN = 256,
  parameter int T1_LEN = 193
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fs_i,
  input logic             lock_w,
  input logic             load_w,
  input logic             hit_w,
  input logic             mf_act_w,
  input logic [POS_W-1:0] pos_w,
  input rxm_cfg_t         cfg_w,
  input logic [1:0]       rise_w
);

  // R2
  pos_zero_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_i |-> pos_w == '0);

  // R2
  pos_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_w |-> int'(pos_w) < frame_len(cfg_w.t1, E1_LEN, T1_LEN));

  // R3
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_w |=> (!hit_w || fs_i || load_w));

  // R1
  idle_mf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_w |=> !rise_w[1]);

  // R1
  idle_fm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_w |=> rise_w[0] == $past(cfg_w.sync_mode));

  // R6
  mf_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mf_act_w |=> rise_w[1]);

endmodule

bind rx_marker_gen rxm_chk #(.E1_LEN(E1_LEN), .T1_LEN(T1_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .fs_i(fs_i), .lock_w(lock_w), .load_w(load_w),
  .hit_w(hit_w), .mf_act_w(mf_act_w), .pos_w(pos_w), .cfg_w(cfg_w), .rise_w(rise_w)
);

// File: tb/sim_rx_marker_gen.sv
`timescale 1ns/1ps
module sim_rx_marker_gen;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs_i = 0, mfs_i = 0, cas_i = 0;
  logic t1_mode_i = 0, sync_mode_i = 0, mf_sel_i = 0, cas_en_i = 0;
  logic [1:0] fmt_i = 0;
  logic [8:0] offset_i = 9'd5;
  logic fall_edge_i = 0;
  logic frame_mark_o, mf_begin_o;

  int errors = 0;
  int checks = 0;
  bit chk_on = 0;
  bit done = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  rx_marker_gen u0 (
    .clk(clk), .rst_n(rst_n), .fs_i(fs_i), .mfs_i(mfs_i), .cas_i(cas_i),
    .t1_mode_i(t1_mode_i), .sync_mode_i(sync_mode_i), .mf_sel_i(mf_sel_i),
    .cas_en_i(cas_en_i), .fmt_i(fmt_i), .offset_i(offset_i), .fall_edge_i(fall_edge_i),
    .frame_mark_o(frame_mark_o), .mf_begin_o(mf_begin_o)
  );

  // Behavioural reference model
  bit lk; int ps; int fc;
  bit m_t1, m_sync, m_sel, m_cas, m_fall; int m_fmt, m_off;
  bit e_fm, e_mf, p_fm, p_mf;

  task automatic take_cfg();
    m_t1 = t1_mode_i; m_sync = sync_mode_i; m_sel = mf_sel_i; m_cas = cas_en_i;
    m_fmt = fmt_i; m_off = offset_i; m_fall = fall_edge_i;
  endtask

  task automatic check(input string what, input bit got, input bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %b exp %b at %0t", tag, what, got, exp, $time);
    end
  endtask

  always begin
    @(posedge clk);
    p_fm = e_fm; p_mf = e_mf;
    if (!rst_n) begin
      lk = 0; ps = 0; fc = 0; take_cfg();
      e_fm = sync_mode_i; e_mf = 0;
    end else begin
      int flen, np, lim; bit ln, h, fb, ex, src;
      flen = m_t1 ? 193 : 256;
      np = fs_i ? 0 : ((ps + 1) % flen);
      ln = lk || fs_i;
      if (!lk || np == 0) take_cfg();
      flen = m_t1 ? 193 : 256;
      h = ln && (np == m_off % flen);
      e_fm = m_sync ? !h : h;
      fb = ln && np == 0;
      if (mfs_i && ln) fc = 0;
      else if (fb && fc < 127) fc++;
      lim = (m_fmt == 3) ? 72 : 24;
      ex = m_t1 && m_sel && m_fmt >= 2 && fb && fc != 0 && (fc % 12 == 0) && fc < lim;
      src = (!m_t1 && m_cas) ? cas_i : mfs_i;
      e_mf = ln && (src || ex);
      lk = ln; ps = np;
    end
    #5;
    if (chk_on) begin  // R5: early in the cycle only the rising-edge launch has moved
      check("R5 early frame_mark_o", frame_mark_o, m_fall ? p_fm : e_fm);
      check("R5 early mf_begin_o", mf_begin_o, m_fall ? p_mf : e_mf);
    end
    #10;
    if (chk_on) begin
      check("frame_mark_o", frame_mark_o, e_fm);
      check("mf_begin_o", mf_begin_o, e_mf);
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      step(); fs_i = 0; mfs_i = 0; cas_i = 0;
    end
  endtask

  task automatic run(input int nfr, input int flen, input int mfp, input int casph);
    for (int f = 0; f < nfr; f++)
      for (int b = 0; b < flen; b++) begin
        step();
        fs_i  = (b == 0);
        mfs_i = (b == 0) && (f % mfp == 0);
        cas_i = (b == 0) && (f % mfp == casph);
      end
  endtask

  task automatic do_reset();
    step(); rst_n = 0; fs_i = 0; mfs_i = 0; cas_i = 0;
    idle(4);
    rst_n = 1;
  endtask

  initial begin
    do_reset();
    chk_on = 1;
    tag = "R1"; idle(40);
    tag = "R3/R6/R2"; run(34, 256, 16, 3);
    tag = "R2"; idle(600);
    idle(100); run(3, 256, 16, 3);
    tag = "R7"; idle(37); cas_en_i = 1; run(20, 256, 16, 3);
    tag = "R10"; idle(90); offset_i = 9'd300; run(4, 256, 16, 3);
    tag = "R4/R5"; idle(70); sync_mode_i = 1; fall_edge_i = 1; run(4, 256, 16, 3);
    tag = "R8"; t1_mode_i = 1; offset_i = 9'd200; mf_sel_i = 0; fmt_i = 2;
    sync_mode_i = 0; fall_edge_i = 0; run(50, 193, 24, 5);
    tag = "R9"; mf_sel_i = 1; run(50, 193, 24, 5);
    fmt_i = 3; run(150, 193, 72, 5);
    fmt_i = 1; run(30, 193, 12, 5);
    tag = "R10"; idle(20); t1_mode_i = 0; run(5, 256, 16, 3);
    chk_on = 0; sync_mode_i = 1;
    do_reset();
    chk_on = 1; tag = "R1"; idle(40);
    chk_on = 0;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule